// File: doc/BRIEF.md
# Shared-Interval Input Deglitch Filter

This block cleans glitches off a bank of digital inputs. The inputs are grouped into 8-channel ports. Every raw input first passes a two-flop synchroniser. A channel whose bit is set in its port's enable byte drives a new level on its filtered output only once the synchronised input has stayed at that level for a programmed number of timebase ticks. A channel whose bit is clear passes the synchronised input straight to its output.

All filtered channels share one interval register. The interval is counted in ticks of a fixed 200 ns timebase, which a prescaler derives from the system clock (a divide by 10 at 50 MHz). A host programs the block through a single-cycle write port. At reset every enable byte is zero and the interval is zero, so all channels start out in pass-through mode.

Top module: `in_deglitch`

## Requirements
- R1: After reset all enable bytes are 0 and the interval is 0, so each output equals its raw input once the synchroniser delay has passed.
- R2: A channel whose enable bit is clear copies its raw input to its output with a latency of exactly two clock edges.
- R3: A filtered channel with interval N (N >= 1) takes on a new input level no later than 2 + N*CLK_DIV clock edges after the raw input changes, as long as the input holds.
- R4: A pulse on a filtered channel that lasts (N-1)*CLK_DIV clocks or less never reaches the output.
- R5: When the interval is 0, an enabled channel behaves like a bypassed one, with a latency of two edges.
- R6: A write to address EN_BASE + 16*p sets the enable byte of port p, and bit b of that byte controls channel 8*p+b. The other ports keep their enable bytes.
- R7: A write to address 0x08 loads wr_data[19:0] into the interval. Bits 31:20 of the write data are ignored.
- R8: Rewriting the interval leaves the outputs that are already held unchanged. The new value takes effect at the channel's next counter reload.
- R9: A filtered output does not change earlier than 3 + (N-1)*CLK_DIV edges after the raw input changes, because the timebase ticks once every CLK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| din | input | NUM_PORTS*8 | Raw inputs, bit 8*p+b is channel b of port p |
| dout | output | NUM_PORTS*8 | Filtered or bypassed outputs |

## Verification
The hardest situation to reach is a pulse that ends just short of the interval while the prescaler phase is unknown, because the number of ticks that land inside the pulse depends on that phase. The bench chooses pulse and hold lengths with a full tick period of margin on each side of the boundary: a level that holds for (N-1)*CLK_DIV clocks must still show the old value, and one that holds for 2+N*CLK_DIV clocks must show the new value. The bench also rewrites the interval while a channel holds a level, and writes an interval with junk in the upper bits, to show that a held value survives the write and that only the low 20 bits set the timing.

// File: rtl/in_deglitch_pkg.sv
package in_deglitch_pkg;
   localparam int CH_PER_PORT = 8;
   localparam int REG_W       = 32;
   typedef logic [CH_PER_PORT-1:0] port_mask_t;
endpackage

// File: rtl/in_deglitch_tick.sv
module in_deglitch_tick #(
   parameter int CLK_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   if (CLK_DIV == 1) begin : g_div1
      assign tick = 1'b1;
   end else begin : g_divn
      logic [CW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           phase <= '0;
         else if (phase == CW'(CLK_DIV - 1))   phase <= '0;
         else                                  phase <= phase + 1'b1;
      end
      assign tick = (phase == CW'(CLK_DIV - 1));

      a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/in_deglitch_regs.sv
module in_deglitch_regs
   import in_deglitch_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 8,
   parameter int IVL_W     = 20,
   parameter int IVL_ADDR  = 'h08,
   parameter int EN_BASE   = 'h44,
   parameter int EN_STRIDE = 'h10
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [REG_W-1:0]                  wr_data,
   output logic [IVL_W-1:0]                  ivl,
   output logic [NUM_PORTS*CH_PER_PORT-1:0]  en_mask
);
   if (EN_BASE + (NUM_PORTS-1)*EN_STRIDE >= (1 << ADDR_W)) begin : g_bad_map
      $error("enable registers exceed the address space");
   end
   if (IVL_W > REG_W) begin : g_bad_ivl
      $error("IVL_W wider than the register");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ivl <= '0;
      else if (wr_en && wr_addr == ADDR_W'(IVL_ADDR))    ivl <= wr_data[IVL_W-1:0];
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(EN_BASE + p*EN_STRIDE);
      port_mask_t mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             mask_q <= '0;
         else if (wr_en && wr_addr == PADDR)     mask_q <= wr_data[CH_PER_PORT-1:0];
      end
      assign en_mask[p*CH_PER_PORT +: CH_PER_PORT] = mask_q;
   end

   a_r7_ivl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(IVL_ADDR)) |=> ivl == $past(wr_data[IVL_W-1:0]));
endmodule

// File: rtl/in_deglitch_chan.sv
module in_deglitch_chan #(
   parameter int IVL_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             raw,
   input  logic             en,
   input  logic [IVL_W-1:0] ivl,
   output logic             out
);
   logic             meta, sync;
   logic             held;
   logic [IVL_W-1:0] cnt;
   logic             ivl_zero;

   assign ivl_zero = (ivl == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= 1'b0;
         sync <= 1'b0;
      end else begin
         meta <= raw;
         sync <= meta;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         cnt  <= '0;
      end else if (!en || ivl_zero) begin
         held <= sync;
         cnt  <= ivl;
      end else if (sync == held) begin
         cnt  <= ivl;
      end else if (tick) begin
         if (cnt <= IVL_W'(1)) begin
            held <= sync;
            cnt  <= ivl;
         end else begin
            cnt  <= cnt - 1'b1;
         end
      end
   end

   assign out = (en && !ivl_zero) ? held : sync;

   a_r3_held_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held) |-> held == $past(sync));
   a_r9_no_change_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ivl_zero && !tick) |=> $stable(held));
   a_r8_reload_when_settled: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sync == held) |=> cnt == $past(ivl));
endmodule

// File: rtl/in_deglitch.sv
module in_deglitch
   import in_deglitch_pkg::*;
#(
   parameter int NUM_PORTS = 2,
   parameter int CLK_DIV   = 10,
   parameter int ADDR_W    = 8,
   parameter int IVL_W     = 20,
   localparam int NCH      = NUM_PORTS * CH_PER_PORT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [NCH-1:0]    din,
   output logic [NCH-1:0]    dout
);
   logic             tick;
   logic [IVL_W-1:0] ivl;
   logic [NCH-1:0]   en_mask;

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end

   in_deglitch_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   in_deglitch_regs #(
      .NUM_PORTS(NUM_PORTS),
      .ADDR_W   (ADDR_W),
      .IVL_W    (IVL_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .ivl    (ivl),
      .en_mask(en_mask)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      in_deglitch_chan #(.IVL_W(IVL_W)) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .raw  (din[c]),
         .en   (en_mask[c]),
         .ivl  (ivl),
         .out  (dout[c])
      );
   end
endmodule

// File: tb/in_deglitch_tb.sv
module in_deglitch_tb;
   localparam int CLK_PERIOD = 20;
   localparam int DIV        = 10;
   localparam int NCH        = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [7:0]      wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [NCH-1:0]  din = '0;
   logic [NCH-1:0]  dout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   in_deglitch u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .din(din), .dout(dout)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      din = 16'hA5C3;
      step(3);
      chk("R1 reset pass-through", dout, 16'hA5C3);
   endtask

   task automatic t_bypass_latency();
      logic [NCH-1:0] old = din;
      din = din ^ 16'h0001;
      step(1);
      chk("R2 one edge still old", dout, old);
      step(1);
      chk("R2 two edges new", dout, din);
   endtask

   task automatic t_setup();
      wr(8'h08, 32'd4);
      wr(8'h44, 32'h01);
      wr(8'h54, 32'h02);
      step(3);
      chk("R6 settled after enable", dout, din);
   endtask

   task automatic t_hold_timing();
      logic [NCH-1:0] old = dout;
      din[0] = ~din[0];
      step(2 + 3*DIV);
      chk("R9 no early change", dout, old);
      step(DIV);
      chk("R3 held level passes", dout, din);
   endtask

   task automatic t_port_decode();
      logic [NCH-1:0] old = dout;
      din[1] = ~din[1];
      din[9] = ~din[9];
      step(3);
      chk("R6 ch1 bypassed, ch9 filtered", dout, {old[15:10], old[9], din[8:0]});
      step(4*DIV);
      chk("R6 ch9 after interval", dout, din);
   endtask

   task automatic t_glitch();
      logic [NCH-1:0] old = dout;
      din[0] = ~din[0];
      step(25);
      chk("R4 glitch mid", dout, old);
      step(5);
      din[0] = ~din[0];
      step(60);
      chk("R4 glitch suppressed", dout, old);
   endtask

   task automatic t_upper_bits();
      logic [NCH-1:0] old;
      wr(8'h08, 32'hFFF0_0003);
      step(2);
      old = dout;
      din[0] = ~din[0];
      step(2 + 2*DIV);
      chk("R7 interval 3 not early", dout, old);
      step(DIV);
      chk("R7 upper bits ignored", dout, din);
   endtask

   task automatic t_rewrite();
      logic [NCH-1:0] old = dout;
      wr(8'h08, 32'd100);
      chk("R8 held after rewrite", dout, old);
      step(20);
      chk("R8 still held", dout, old);
      din[0] = ~din[0];
      step(50);
      chk("R8 new interval in effect", dout, old);
      din[0] = ~din[0];
      step(3);
   endtask

   task automatic t_zero_interval();
      logic [NCH-1:0] old;
      wr(8'h08, 32'd0);
      step(2);
      old = dout;
      din[0] = ~din[0];
      step(1);
      chk("R5 zero interval one edge", dout, old);
      step(1);
      chk("R5 zero interval two edges", dout, din);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_bypass_latency();
      t_setup();
      t_hold_timing();
      t_port_decode();
      t_glitch();
      t_upper_bits();
      t_rewrite();
      t_zero_interval();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule